// File: doc/BRIEF.md
# Sharing-Aware Mostly-Exclusive Outer Cache

This block is a shared, set-associative outer cache that sits behind several per-core inner caches. It holds only lines that the inner caches have evicted. Those victims arrive through an insert request. When a core asks for a line and the cache holds it, the line is returned in the next cycle. The cache then decides whether to keep its own copy. A line that looks private to one core is dropped, so the hierarchy stays mostly exclusive. A line that looks shared is kept, so other cores can still hit on it.

Each way carries a valid bit, a sharing-history bit and the id of the core that last held the line. A read from a core other than the last holder sets the history bit. So does any instruction fetch. Once set, the bit keeps the line resident on every later hit. A miss is not allocated. The block raises a memory request for the address, and the line from memory goes straight to the core. Replacement uses a 3-bit tree pseudo-LRU per set, restricted to the unshared ways whenever at least one of them exists.

Requests come one per cycle. Each carries a 2-bit kind, a core id, a line address and insert data. The low SET_W address bits select the set, and the remaining bits form the tag. All state updates and all outputs take effect at the clock edge that samples the request.

Top module: `mxv_cache`

## Requirements
- R1: After reset no line is valid, and rsp_valid and mem_req_valid are low. Any read that follows reset misses.
- R2: A data read (kind 2'b00) or code fetch (kind 2'b01) that misses gives, one cycle later, rsp_valid=1, rsp_hit=0, mem_req_valid=1 and mem_req_addr equal to the request address. Nothing is allocated, so a repeat of the same read misses again.
- R3: A victim insert (kind 2'b10) to an absent address allocates the line and gives neither a response nor a memory request. A following read of that address hits, one cycle later, with the inserted data on rsp_data.
- R4: A data read that hits a line whose history bit is clear, coming from the same core that last held the line, returns the line and removes it from the cache.
- R5: A data read that hits from a core other than the last holder returns the line, keeps it and sets its history bit. Later reads from any core, including the new holder, keep it as well.
- R6: A code fetch that hits always keeps the line and sets its history bit.
- R7: A victim insert to an address that is already resident overwrites its data in place and makes that core the last holder.
- R8: An insert into a set with a free way takes the lowest-numbered free way. A set therefore holds four lines before anything is evicted.
- R9: An insert into a full set evicts by tree pseudo-LRU among the ways whose history bit is clear. Tree bit 0 selects ways 0-1 when 0 and ways 2-3 when 1. Bit 1 selects within ways 0-1, and bit 2 selects within ways 2-3, each picking the lower way when 0. Any access to a way points the bits on its path away from it. If the preferred branch holds no candidate, the other branch is taken.
- R10: When every way of a full set is shared, an insert evicts the way named by the plain tree pseudo-LRU.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 00 data read, 01 code fetch, 10 victim insert, 11 idle |
| req_core | input | CORE_W | Requesting core id |
| req_addr | input | ADDR_W | Line address; low SET_W bits are the set index |
| req_wdata | input | DATA_W | Line data for a victim insert |
| rsp_valid | output | 1 | Response to a read or fetch |
| rsp_hit | output | 1 | Response is a hit |
| rsp_data | output | DATA_W | Line data on a hit, zero otherwise |
| mem_req_valid | output | 1 | Miss forwarded to memory |
| mem_req_addr | output | ADDR_W | Address of the forwarded miss |

## Verification
Some properties are checked by assertions on every cycle:
- each read or fetch is answered in the next cycle;
- a miss raises a memory request for the same address;
- an insert stays silent;
- the retain-or-drop decision matches the fetch kind, the history bit and the last holder;
- allocation uses a free way before any occupied one, and never evicts a shared way while an unshared one exists.

Other behaviours can only be shown by the bench's request sequences. These are the exact pseudo-LRU order among the unshared ways, the fallback order when all ways are shared, the persistence of the history bit across later reads, in-place overwrite of resident data, and the loss of all lines on a mid-run reset.

// File: rtl/mxv_pkg.sv
package mxv_pkg;

  localparam int WAYS = 4;

  typedef enum logic [1:0] {
    KIND_DATA   = 2'b00,
    KIND_CODE   = 2'b01,
    KIND_VICTIM = 2'b10,
    KIND_IDLE   = 2'b11
  } kind_e;

  // Point the tree bits on the path to way w away from it.
  function automatic logic [2:0] plru_touch(logic [2:0] bits, logic [1:0] w);
    logic [2:0] nb;
    nb = bits;
    nb[0] = ~w[1];
    if (!w[1]) nb[1] = ~w[0];
    else       nb[2] = ~w[0];
    return nb;
  endfunction

  // Follow the tree toward candidates in mask; an empty mask means all ways.
  function automatic logic [1:0] plru_pick(logic [2:0] bits, logic [3:0] mask);
    logic [3:0] m;
    logic       side;
    logic [1:0] pm;
    logic       pb;
    logic       lo;
    m = (mask == 4'b0000) ? 4'b1111 : mask;
    if (bits[0]) side = (m[3:2] != 2'b00) ? 1'b1 : 1'b0;
    else         side = (m[1:0] != 2'b00) ? 1'b0 : 1'b1;
    pm = side ? m[3:2] : m[1:0];
    pb = side ? bits[2] : bits[1];
    if (pb) lo = pm[1] ? 1'b1 : 1'b0;
    else    lo = pm[0] ? 1'b0 : 1'b1;
    return {side, lo};
  endfunction

  // Index of the lowest set bit (zero when none).
  function automatic logic [1:0] lowest_one(logic [3:0] v);
    logic [1:0] r;
    r = 2'd0;
    for (int i = 3; i >= 0; i--) begin
      if (v[i]) r = 2'(i);
    end
    return r;
  endfunction

endpackage

// File: rtl/mxv_hit_detect.sv
module mxv_hit_detect import mxv_pkg::*; #(
  parameter int TAG_W = 13
) (
  input  logic [WAYS-1:0]             way_valid,
  input  logic [WAYS-1:0][TAG_W-1:0]  way_tag,
  input  logic [TAG_W-1:0]            req_tag,
  output logic                        hit,
  output logic [1:0]                  hit_way
);

  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = way_valid[w] && (way_tag[w] == req_tag);
  end

  assign hit     = |match;
  assign hit_way = lowest_one(match);

endmodule

// File: rtl/mxv_share_judge.sv
module mxv_share_judge #(
  parameter int CORE_W = 2
) (
  input  logic              is_code,
  input  logic              line_shared,
  input  logic [CORE_W-1:0] last_core,
  input  logic [CORE_W-1:0] req_core,
  output logic              keep
);

  // A line stays when it is code, has a sharing history, or changes hands.
  assign keep = is_code | line_shared | (last_core != req_core);

endmodule

// File: rtl/mxv_victim_pick.sv
module mxv_victim_pick import mxv_pkg::*; (
  input  logic [WAYS-1:0] way_valid,
  input  logic [WAYS-1:0] way_shared,
  input  logic [2:0]      plru_bits,
  output logic [1:0]      victim_way
);

  logic            any_free;
  logic [WAYS-1:0] unshared_mask;

  assign any_free      = ~&way_valid;
  assign unshared_mask = way_valid & ~way_shared;
  assign victim_way    = any_free ? lowest_one(~way_valid)
                                  : plru_pick(plru_bits, unshared_mask);

endmodule

// File: rtl/mxv_cache.sv
module mxv_cache import mxv_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int SET_W  = 3,
  parameter int DATA_W = 32,
  parameter int CORE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [CORE_W-1:0] req_core,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr
);

  localparam int SETS  = 1 << SET_W;
  localparam int TAG_W = ADDR_W - SET_W;

  logic [WAYS-1:0]              val_q  [SETS];
  logic [WAYS-1:0]              sh_q   [SETS];
  logic [2:0]                   plru_q [SETS];
  logic [WAYS-1:0][TAG_W-1:0]   tag_q  [SETS];
  logic [WAYS-1:0][DATA_W-1:0]  dat_q  [SETS];
  logic [WAYS-1:0][CORE_W-1:0]  lc_q   [SETS];

  logic [SET_W-1:0]             req_set;
  logic [TAG_W-1:0]             req_tag;
  logic [WAYS-1:0]              set_v, set_sh;
  logic [WAYS-1:0][TAG_W-1:0]   set_tag;
  logic [WAYS-1:0][DATA_W-1:0]  set_dat;
  logic [WAYS-1:0][CORE_W-1:0]  set_lc;
  logic [2:0]                   set_plru;

  assign req_set  = req_addr[SET_W-1:0];
  assign req_tag  = req_addr[ADDR_W-1:SET_W];
  assign set_v    = val_q[req_set];
  assign set_sh   = sh_q[req_set];
  assign set_tag  = tag_q[req_set];
  assign set_dat  = dat_q[req_set];
  assign set_lc   = lc_q[req_set];
  assign set_plru = plru_q[req_set];

  // Named internal events
  logic              is_read, is_code, is_insert;
  logic              hit_any, rd_hit, upd_hit, alloc_do, keep_line;
  logic [1:0]        hit_way, alloc_way;
  logic              hit_shared;
  logic [CORE_W-1:0] hit_lastc;

  assign is_code   = req_valid && (req_kind == KIND_CODE);
  assign is_read   = req_valid && ((req_kind == KIND_DATA) || (req_kind == KIND_CODE));
  assign is_insert = req_valid && (req_kind == KIND_VICTIM);

  mxv_hit_detect #(.TAG_W(TAG_W)) u_hit (
    .way_valid (set_v),
    .way_tag   (set_tag),
    .req_tag   (req_tag),
    .hit       (hit_any),
    .hit_way   (hit_way)
  );

  assign hit_shared = set_sh[hit_way];
  assign hit_lastc  = set_lc[hit_way];

  mxv_share_judge #(.CORE_W(CORE_W)) u_judge (
    .is_code     (is_code),
    .line_shared (hit_shared),
    .last_core   (hit_lastc),
    .req_core    (req_core),
    .keep        (keep_line)
  );

  mxv_victim_pick u_victim (
    .way_valid  (set_v),
    .way_shared (set_sh),
    .plru_bits  (set_plru),
    .victim_way (alloc_way)
  );

  assign rd_hit   = is_read && hit_any;
  assign upd_hit  = is_insert && hit_any;
  assign alloc_do = is_insert && !hit_any;

  // Control state and outputs
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        val_q[s]  <= '0;
        sh_q[s]   <= '0;
        plru_q[s] <= '0;
      end
      rsp_valid     <= 1'b0;
      rsp_hit       <= 1'b0;
      rsp_data      <= '0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
    end else begin
      if (rd_hit) begin
        if (keep_line) begin
          sh_q[req_set][hit_way] <= 1'b1;
          plru_q[req_set]        <= plru_touch(set_plru, hit_way);
        end else begin
          val_q[req_set][hit_way] <= 1'b0;
        end
      end
      if (upd_hit) begin
        plru_q[req_set] <= plru_touch(set_plru, hit_way);
      end
      if (alloc_do) begin
        val_q[req_set][alloc_way] <= 1'b1;
        sh_q[req_set][alloc_way]  <= 1'b0;
        plru_q[req_set]           <= plru_touch(set_plru, alloc_way);
      end
      rsp_valid     <= is_read;
      rsp_hit       <= rd_hit;
      rsp_data      <= rd_hit ? set_dat[hit_way] : '0;
      mem_req_valid <= is_read && !hit_any;
      mem_req_addr  <= (is_read && !hit_any) ? req_addr : '0;
    end
  end

  // Payload arrays: no reset needed, guarded by the valid bits
  always_ff @(posedge clk) begin
    if (rst_n) begin
      if (rd_hit && keep_line) begin
        lc_q[req_set][hit_way] <= req_core;
      end
      if (upd_hit) begin
        dat_q[req_set][hit_way] <= req_wdata;
        lc_q[req_set][hit_way]  <= req_core;
      end
      if (alloc_do) begin
        tag_q[req_set][alloc_way] <= req_tag;
        dat_q[req_set][alloc_way] <= req_wdata;
        lc_q[req_set][alloc_way]  <= req_core;
      end
    end
  end

endmodule

// File: rtl/mxv_checker.sv
module mxv_checker import mxv_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int CORE_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [1:0]        req_kind,
  input logic [CORE_W-1:0] req_core,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic              mem_req_valid,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              rd_hit,
  input logic              keep_line,
  input logic              hit_shared,
  input logic [CORE_W-1:0] hit_lastc,
  input logic              alloc_do,
  input logic [1:0]        alloc_way,
  input logic [WAYS-1:0]   set_v,
  input logic [WAYS-1:0]   set_sh
);

  logic rd_req;
  assign rd_req = req_valid && ((req_kind == KIND_DATA) || (req_kind == KIND_CODE));

  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rsp_valid); // R2

  AST_MISS_FETCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> mem_req_valid); // R2

  AST_MEM_ADDR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> (!mem_req_valid || (mem_req_addr == $past(req_addr)))); // R2

  AST_INSERT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_kind == KIND_VICTIM)) |=> (!rsp_valid && !mem_req_valid)); // R3

  AST_PRIVATE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && (req_kind == KIND_DATA) && !hit_shared && (hit_lastc == req_core)) |-> !keep_line); // R4

  AST_FOREIGN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && (hit_lastc != req_core)) |-> keep_line); // R5

  AST_CODE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && (req_kind == KIND_CODE)) |-> keep_line); // R6

  AST_FREE_WAY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_do && !(&set_v)) |-> !set_v[alloc_way]); // R8

  AST_UNSHARED_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_do && (&set_v) && !(&set_sh)) |-> !set_sh[alloc_way]); // R9

endmodule

bind mxv_cache mxv_checker #(.ADDR_W(ADDR_W), .CORE_W(CORE_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_kind      (req_kind),
  .req_core      (req_core),
  .req_addr      (req_addr),
  .rsp_valid     (rsp_valid),
  .rsp_hit       (rsp_hit),
  .mem_req_valid (mem_req_valid),
  .mem_req_addr  (mem_req_addr),
  .rd_hit        (rd_hit),
  .keep_line     (keep_line),
  .hit_shared    (hit_shared),
  .hit_lastc     (hit_lastc),
  .alloc_do      (alloc_do),
  .alloc_way     (alloc_way),
  .set_v         (set_v),
  .set_sh        (set_sh)
);

// File: tb/tb_mxv_cache.sv
module tb_mxv_cache;

  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] KD = 2'b00, KC = 2'b01, KV = 2'b10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'b11;
  logic [1:0]  req_core = '0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_hit, mem_req_valid;
  logic [31:0] rsp_data;
  logic [15:0] mem_req_addr;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mxv_cache dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_core(req_core), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr)
  );

  typedef struct packed {
    logic [23:0] rq;
    logic [1:0]  kind;
    logic [1:0]  core;
    logic [15:0] addr;
    logic [31:0] wdata;
    logic        e_rsp;
    logic        e_hit;
    logic [31:0] e_data;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{"R2 ", KD, 2'd0, 16'h0012, 32'h0,        1'b1, 1'b0, 32'h0},
    '{"R2 ", KD, 2'd0, 16'h0012, 32'h0,        1'b1, 1'b0, 32'h0},
    '{"R3 ", KV, 2'd0, 16'h0012, 32'hA0000012, 1'b0, 1'b0, 32'h0},
    '{"R3 ", KD, 2'd0, 16'h0012, 32'h0,        1'b1, 1'b1, 32'hA0000012},
    '{"R4 ", KD, 2'd0, 16'h0012, 32'h0,        1'b1, 1'b0, 32'h0},
    '{"R3 ", KV, 2'd1, 16'h0023, 32'hB0000023, 1'b0, 1'b0, 32'h0},
    '{"R5 ", KD, 2'd2, 16'h0023, 32'h0,        1'b1, 1'b1, 32'hB0000023},
    '{"R5 ", KD, 2'd1, 16'h0023, 32'h0,        1'b1, 1'b1, 32'hB0000023},
    '{"R5 ", KD, 2'd1, 16'h0023, 32'h0,        1'b1, 1'b1, 32'hB0000023},
    '{"R3 ", KV, 2'd0, 16'h0034, 32'hC0000034, 1'b0, 1'b0, 32'h0},
    '{"R6 ", KC, 2'd0, 16'h0034, 32'h0,        1'b1, 1'b1, 32'hC0000034},
    '{"R6 ", KD, 2'd0, 16'h0034, 32'h0,        1'b1, 1'b1, 32'hC0000034},
    '{"R7 ", KV, 2'd1, 16'h0023, 32'hB1110023, 1'b0, 1'b0, 32'h0},
    '{"R7 ", KD, 2'd1, 16'h0023, 32'h0,        1'b1, 1'b1, 32'hB1110023},
    '{"R7 ", KD, 2'd3, 16'h0023, 32'h0,        1'b1, 1'b1, 32'hB1110023},
    '{"R2 ", KC, 2'd1, 16'h0045, 32'h0,        1'b1, 1'b0, 32'h0}
  };

  task automatic chk(input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // Drive at a falling edge; return at the next falling edge with results visible.
  task automatic step(input logic [1:0] k, input logic [1:0] c,
                      input logic [15:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_kind = k; req_core = c; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_kind = 2'b11;
  endtask

  task automatic expect_rsp(input string rq, input logic e_rsp, input logic e_hit,
                            input logic [31:0] e_data, input logic [15:0] a);
    chk(rq, "rsp_valid", 64'(rsp_valid), 64'(e_rsp));
    chk(rq, "mem_req_valid", 64'(mem_req_valid), 64'(e_rsp && !e_hit));
    if (e_rsp) begin
      chk(rq, "rsp_hit", 64'(rsp_hit), 64'(e_hit));
      if (e_hit) chk(rq, "rsp_data", 64'(rsp_data), 64'(e_data));
      else       chk(rq, "mem_req_addr", 64'(mem_req_addr), 64'(a));
    end
  endtask

  function automatic logic [31:0] dv(input logic [15:0] a);
    return 32'hD0000000 | 32'(a);
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1: quiet outputs after reset
    chk("R1", "rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1", "mem_req_valid", 64'(mem_req_valid), 64'd0);

    // Vector table walk
    for (int i = 0; i < NV; i++) begin
      step(TBL[i].kind, TBL[i].core, TBL[i].addr, TBL[i].wdata);
      expect_rsp(string'(TBL[i].rq), TBL[i].e_rsp, TBL[i].e_hit, TBL[i].e_data, TBL[i].addr);
    end

    // R8 / R9: set 0 fills four ways, A becomes shared, B..D refreshed
    step(KV, 2'd0, 16'h0008, dv(16'h0008));
    step(KV, 2'd0, 16'h0010, dv(16'h0010));
    step(KV, 2'd0, 16'h0018, dv(16'h0018));
    step(KV, 2'd0, 16'h0020, dv(16'h0020));
    step(KD, 2'd1, 16'h0008, 32'h0);
    expect_rsp("R8", 1'b1, 1'b1, dv(16'h0008), 16'h0008);
    step(KV, 2'd0, 16'h0010, dv(16'h0010));
    step(KV, 2'd0, 16'h0018, dv(16'h0018));
    step(KV, 2'd0, 16'h0020, dv(16'h0020));
    // Plain tree would pick way 0 (shared A); unshared choice is way 1 (B)
    step(KV, 2'd0, 16'h0028, dv(16'h0028));
    expect_rsp("R9", 1'b0, 1'b0, 32'h0, 16'h0028);
    step(KD, 2'd0, 16'h0010, 32'h0);
    expect_rsp("R9", 1'b1, 1'b0, 32'h0, 16'h0010);
    step(KD, 2'd2, 16'h0008, 32'h0);
    expect_rsp("R9", 1'b1, 1'b1, dv(16'h0008), 16'h0008);
    step(KD, 2'd0, 16'h0018, 32'h0);
    expect_rsp("R9", 1'b1, 1'b1, dv(16'h0018), 16'h0018);
    step(KD, 2'd0, 16'h0028, 32'h0);
    expect_rsp("R9", 1'b1, 1'b1, dv(16'h0028), 16'h0028);

    // R10: set 1 all shared through code fetches; plain tree picks way 0
    step(KV, 2'd0, 16'h0009, dv(16'h0009));
    step(KV, 2'd0, 16'h0011, dv(16'h0011));
    step(KV, 2'd0, 16'h0019, dv(16'h0019));
    step(KV, 2'd0, 16'h0021, dv(16'h0021));
    step(KC, 2'd0, 16'h0009, 32'h0);
    expect_rsp("R6", 1'b1, 1'b1, dv(16'h0009), 16'h0009);
    step(KC, 2'd0, 16'h0011, 32'h0);
    expect_rsp("R6", 1'b1, 1'b1, dv(16'h0011), 16'h0011);
    step(KC, 2'd0, 16'h0019, 32'h0);
    expect_rsp("R8", 1'b1, 1'b1, dv(16'h0019), 16'h0019);
    step(KC, 2'd0, 16'h0021, 32'h0);
    expect_rsp("R8", 1'b1, 1'b1, dv(16'h0021), 16'h0021);
    step(KV, 2'd0, 16'h0029, dv(16'h0029));
    step(KD, 2'd0, 16'h0009, 32'h0);
    expect_rsp("R10", 1'b1, 1'b0, 32'h0, 16'h0009);
    step(KD, 2'd1, 16'h0011, 32'h0);
    expect_rsp("R10", 1'b1, 1'b1, dv(16'h0011), 16'h0011);
    step(KD, 2'd1, 16'h0029, 32'h0);
    expect_rsp("R10", 1'b1, 1'b1, dv(16'h0029), 16'h0029);

    // R1: a mid-run reset drops resident shared lines
    do_reset();
    chk("R1", "rsp_valid", 64'(rsp_valid), 64'd0);
    step(KD, 2'd1, 16'h0023, 32'h0);
    expect_rsp("R1", 1'b1, 1'b0, 32'h0, 16'h0023);
    step(KD, 2'd2, 16'h0011, 32'h0);
    expect_rsp("R1", 1'b1, 1'b0, 32'h0, 16'h0011);

    summary();
    $finish;
  end

endmodule